// File: doc/BRIEF.md
# Multi-Channel Shared-Memory Packet FIFO

This block buffers packets for several independent channels inside one shared memory array. The array is cut into equal, fixed-size segments, one per channel. A streaming sink carries a word together with a channel number, start-of-packet, end-of-packet and error markers. Each word is stored in the segment of its channel. A packet becomes visible to the reader only when its end-of-packet beat has been accepted without any error. A packet that carries an error on any beat, or that does not fit in the space left in its segment, is discarded as a whole.

Words are fetched through a memory-mapped request port. A write strobe plus a channel number asks for exactly one word of that channel. The word appears on a streaming source three cycles after the request cycle, tagged with its channel. If the channel holds no complete packet, the source valid stays low for that request and nothing is consumed. A system that has no request master ties the strobe high with channel 0, so channel 0 drains at one word per cycle.

Top module: `mcpkt_fifo`

## Requirements
- R1: After reset the source valid is low and every channel is empty, so a request to any channel returns no data.
- R2: The words of an error-free packet are returned in arrival order, one word per request, on the requested channel, and `out_channel` equals the requested channel.
- R3: A packet with `in_error` high on any of its beats is dropped completely, and words committed earlier on that channel are still returned unchanged.
- R4: No word of a packet is returned before the beat with `in_eop` high has been accepted; after that beat, all of its words become readable.
- R5: Each channel holds at most SEG_DEPTH words, counting both committed and in-progress words. A packet that needs more room than is left is dropped in full, and a later packet that fits is still accepted.
- R6: A request sampled in cycle n gives its result in cycle n+3. `out_valid` is high for exactly that one cycle for each request that is served, and low in the two cycles before it.
- R7: A request to a channel with no committed word keeps `out_valid` low and consumes nothing, so a later request still returns that channel's next committed word.
- R8: Channels are isolated: writes and reads on one channel never change the data or the availability of another channel.
- R9: A beat with `in_sop` high discards any unfinished words of the same channel and starts a new packet.
- R10: With `req_write` held high and `req_channel` at 0, channel 0 returns one word per cycle until it is empty. After that, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sink beat present |
| in_data | input | SYMS*SYM_W | Sink data word |
| in_channel | input | CH_W | Channel of the sink beat |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_error | input | 1 | Beat belongs to a corrupted packet |
| req_write | input | 1 | Request strobe for one word |
| req_channel | input | CH_W | Channel whose word is requested |
| out_valid | output | 1 | Source word valid |
| out_data | output | SYMS*SYM_W | Source data word |
| out_channel | output | CH_W | Channel of the source word |

## Verification
The assertions assume that the sink channel number and the request channel number always lie below NUM_CH. They also assume that every beat the sink presents is taken, because the block has no backpressure. The checks on pointer distance depend on the segment depth being a power of two. The bench keeps each phase apart: a whole packet is written before any request is made, and each request is allowed to leave the pipeline before the next write. This keeps the bench's occupancy model in step with the moment the read pointer moves. Random channel numbers are drawn only from 0 to NUM_CH-1.

// File: rtl/mcpkt_pkg.sv
package mcpkt_pkg;

  // Flat address of a slot: segment base plus the pointer folded into the segment.
  function automatic int unsigned seg_addr(input int unsigned ch, input int unsigned ptr,
                                           input int unsigned depth);
    return ch * depth + (ptr % depth);
  endfunction

  // Distance from a trailing pointer to a leading one, modulo the pointer range.
  function automatic int unsigned ptr_fill(input int unsigned lead, input int unsigned trail,
                                           input int unsigned ptr_w);
    return (lead - trail) & ((32'd1 << ptr_w) - 32'd1);
  endfunction

endpackage

// File: rtl/mcpkt_seg_mem.sv
module mcpkt_seg_mem #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 32,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/mcpkt_wr_ctrl.sv
module mcpkt_wr_ctrl
  import mcpkt_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int SEG_DEPTH = 8,
  parameter int DATA_W    = 16,
  parameter int CH_W      = 2,
  parameter int PTR_W     = 4,
  parameter int ADDR_W    = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [DATA_W-1:0]            in_data,
  input  logic [CH_W-1:0]              in_channel,
  input  logic                         in_sop,
  input  logic                         in_eop,
  input  logic                         in_error,
  input  logic [NUM_CH-1:0][PTR_W-1:0] rd_ptr,
  output logic [NUM_CH-1:0][PTR_W-1:0] comm_ptr,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_waddr,
  output logic [DATA_W-1:0]            mem_wdata
);
  logic [NUM_CH-1:0][PTR_W-1:0] wr_q, comm_q;
  logic [NUM_CH-1:0]            bad_q;

  logic [PTR_W-1:0] base_wr, adv_wr;
  logic             base_bad, seg_full, bad_n;
  logic             commit_ev, rollback_ev;

  always_comb begin
    base_wr  = in_sop ? comm_q[in_channel] : wr_q[in_channel];
    base_bad = in_sop ? 1'b0 : bad_q[in_channel];
    seg_full = ptr_fill(int'(base_wr), int'(rd_ptr[in_channel]), PTR_W) >= SEG_DEPTH;
    bad_n    = base_bad | in_error | seg_full;
    adv_wr   = bad_n ? base_wr : base_wr + PTR_W'(1);
  end

  assign mem_we      = in_valid & ~bad_n;
  assign mem_waddr   = ADDR_W'(seg_addr(int'(in_channel), int'(base_wr), SEG_DEPTH));
  assign mem_wdata   = in_data;
  assign commit_ev   = in_valid & in_eop & ~bad_n;
  assign rollback_ev = in_valid & in_eop & bad_n;
  assign comm_ptr    = comm_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wr_q[c]   <= '0;
        comm_q[c] <= '0;
        bad_q[c]  <= 1'b0;
      end else if (in_valid && in_channel == CH_W'(c)) begin
        if (in_eop) begin
          bad_q[c] <= 1'b0;
          if (bad_n) begin
            wr_q[c] <= comm_q[c];
          end else begin
            wr_q[c]   <= adv_wr;
            comm_q[c] <= adv_wr;
          end
        end else begin
          wr_q[c]  <= adv_wr;
          bad_q[c] <= bad_n;
        end
      end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_fill(int'(wr_q[c]), int'(rd_ptr[c]), PTR_W) <= SEG_DEPTH); // R5
  end

  AST_ROLLBACK_TO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_ev |=> wr_q[$past(in_channel)] == comm_q[$past(in_channel)]); // R3

  AST_COMMIT_ONLY_AT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_eop) |=> $stable(comm_q)); // R4

  AST_COMMIT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev && !in_sop |=> comm_q[$past(in_channel)] != $past(comm_q[in_channel])); // R2
endmodule

// File: rtl/mcpkt_rd_pipe.sv
module mcpkt_rd_pipe
  import mcpkt_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int SEG_DEPTH = 8,
  parameter int DATA_W    = 16,
  parameter int CH_W      = 2,
  parameter int PTR_W     = 4,
  parameter int ADDR_W    = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_write,
  input  logic [CH_W-1:0]              req_channel,
  input  logic [NUM_CH-1:0][PTR_W-1:0] comm_ptr,
  output logic [NUM_CH-1:0][PTR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0]            mem_raddr,
  input  logic [DATA_W-1:0]            mem_rdata,
  output logic                         out_valid,
  output logic [DATA_W-1:0]            out_data,
  output logic [CH_W-1:0]              out_channel
);
  logic [NUM_CH-1:0][PTR_W-1:0] rd_q;
  logic            s1_v, s2_v, s1_avail;
  logic [CH_W-1:0] s1_ch, s2_ch;

  assign s1_avail  = s1_v && ptr_fill(int'(comm_ptr[s1_ch]), int'(rd_q[s1_ch]), PTR_W) != 0;
  assign mem_raddr = ADDR_W'(seg_addr(int'(s1_ch), int'(rd_q[s1_ch]), SEG_DEPTH));
  assign rd_ptr    = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;  s1_ch <= '0;
      s2_v <= 1'b0;  s2_ch <= '0;
      out_valid <= 1'b0; out_channel <= '0; out_data <= '0;
    end else begin
      s1_v  <= req_write;
      s1_ch <= req_channel;
      s2_v  <= s1_avail;
      s2_ch <= s1_ch;
      out_valid   <= s2_v;
      out_channel <= s2_ch;
      out_data    <= s2_v ? mem_rdata : '0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n) rd_q[c] <= '0;
      else if (s1_avail && s1_ch == CH_W'(c)) rd_q[c] <= rd_q[c] + PTR_W'(1);
    end

    AST_READ_BEHIND_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_fill(int'(comm_ptr[c]), int'(rd_q[c]), PTR_W) <= SEG_DEPTH); // R7
  end

  AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(req_write, 3)); // R6

  AST_CHANNEL_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_channel == $past(req_channel, 3)); // R2
endmodule

// File: rtl/mcpkt_fifo.sv
module mcpkt_fifo
  import mcpkt_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int SEG_DEPTH = 8,
  parameter int SYMS      = 2,
  parameter int SYM_W     = 8,
  localparam int DATA_W   = SYMS * SYM_W,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PTR_W    = $clog2(SEG_DEPTH) + 1,
  localparam int WORDS    = NUM_CH * SEG_DEPTH,
  localparam int ADDR_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CH_W-1:0]   in_channel,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_error,
  input  logic              req_write,
  input  logic [CH_W-1:0]   req_channel,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CH_W-1:0]   out_channel
);
  if (!(NUM_CH == 1 || NUM_CH == 2 || NUM_CH == 4 || NUM_CH == 8 || NUM_CH == 16))
    begin : g_bad_ch
      $error("NUM_CH must be 1, 2, 4, 8 or 16");
    end
  if (SEG_DEPTH < 2 || (SEG_DEPTH & (SEG_DEPTH - 1)) != 0) begin : g_bad_depth
    $error("SEG_DEPTH must be a power of two, at least 2");
  end

  logic [NUM_CH-1:0][PTR_W-1:0] comm_ptr, rd_ptr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  mcpkt_wr_ctrl #(.NUM_CH(NUM_CH), .SEG_DEPTH(SEG_DEPTH), .DATA_W(DATA_W), .CH_W(CH_W),
                  .PTR_W(PTR_W), .ADDR_W(ADDR_W)) wr_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_channel(in_channel), .in_sop(in_sop), .in_eop(in_eop), .in_error(in_error),
    .rd_ptr(rd_ptr), .comm_ptr(comm_ptr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

  mcpkt_seg_mem #(.DATA_W(DATA_W), .WORDS(WORDS)) mem_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata));

  mcpkt_rd_pipe #(.NUM_CH(NUM_CH), .SEG_DEPTH(SEG_DEPTH), .DATA_W(DATA_W), .CH_W(CH_W),
                  .PTR_W(PTR_W), .ADDR_W(ADDR_W)) rd_i (
    .clk(clk), .rst_n(rst_n), .req_write(req_write), .req_channel(req_channel),
    .comm_ptr(comm_ptr), .rd_ptr(rd_ptr), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_channel(out_channel));
endmodule

// File: tb/mcpkt_fifo_tb_top.sv
module mcpkt_fifo_tb_top;
  localparam int NCH = 4, DEPTH = 8, DW = 16, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_error = 0, req_write = 0;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] in_channel = '0, req_channel = '0;
  logic out_valid;
  logic [DW-1:0] out_data;
  logic [CW-1:0] out_channel;

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [DW-1:0] q_comm [NCH][$];
  logic [DW-1:0] q_pend [NCH][$];
  bit            bad [NCH];

  always #4 clk = ~clk;

  mcpkt_fifo #(.NUM_CH(NCH), .SEG_DEPTH(DEPTH), .SYMS(2), .SYM_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_channel(in_channel), .in_sop(in_sop), .in_eop(in_eop), .in_error(in_error),
    .req_write(req_write), .req_channel(req_channel),
    .out_valid(out_valid), .out_data(out_data), .out_channel(out_channel));

  function automatic int room_left(int ch);
    return DEPTH - q_comm[ch].size() - q_pend[ch].size();
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat(int ch, logic [DW-1:0] d, bit sop, bit eop, bit err);
    @(negedge clk);
    in_valid = 1; in_channel = CW'(ch); in_data = d;
    in_sop = sop; in_eop = eop; in_error = err;
    if (sop) begin q_pend[ch].delete(); bad[ch] = 0; end
    if (err) bad[ch] = 1;
    if (!bad[ch]) begin
      if (room_left(ch) <= 0) bad[ch] = 1;
      else q_pend[ch].push_back(d);
    end
    if (eop) begin
      if (!bad[ch]) foreach (q_pend[ch][i]) q_comm[ch].push_back(q_pend[ch][i]);
      q_pend[ch].delete();
      bad[ch] = 0;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0; in_error = 0;
  endtask

  task automatic send_pkt(int ch, int len, int err_at);
    for (int i = 0; i < len; i++)
      beat(ch, DW'($urandom), i == 0, i == len - 1, i == err_at);
    idle();
  endtask

  task automatic do_req(int ch, string req);
    bit exp_v;
    logic [DW-1:0] exp_d;
    exp_v = q_comm[ch].size() > 0;
    exp_d = exp_v ? q_comm[ch].pop_front() : '0;
    @(negedge clk); req_write = 1; req_channel = CW'(ch);
    @(negedge clk); req_write = 0;
    chk(out_valid == 0, "R6 early", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 0, "R6 early", out_valid, 0);
    @(negedge clk);
    chk(out_valid == exp_v, req, out_valid, exp_v);
    if (exp_v) begin
      chk(out_data == exp_d, req, out_data, exp_d);
      chk(out_channel == CW'(ch), "R2 channel", out_channel, ch);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    chk(out_valid == 0, "R1 reset valid", out_valid, 0);
    rst_n = 1;
    for (int c = 0; c < NCH; c++) do_req(c, "R1 empty after reset");

    // R2 / R8: clean packet on channel 1, channel 2 stays empty
    send_pkt(1, 3, -1);
    do_req(2, "R8 other channel empty");
    for (int i = 0; i < 3; i++) do_req(1, "R2 in-order word");
    do_req(1, "R7 drained channel");

    // R3: committed word survives a dropped packet
    send_pkt(0, 2, -1);
    send_pkt(0, 3, 1);
    send_pkt(0, 2, 1);
    for (int i = 0; i < 3; i++) do_req(0, "R3 error packet dropped");

    // R4: partial packet not visible until end-of-packet
    beat(3, 16'hA001, 1, 0, 0);
    beat(3, 16'hA002, 0, 0, 0);
    idle();
    do_req(3, "R4 partial hidden");
    beat(3, 16'hA003, 0, 1, 0);
    idle();
    for (int i = 0; i < 4; i++) do_req(3, "R4 released at eop");

    // R5: overflow drops the whole packet, a fitting one follows
    send_pkt(2, 6, -1);
    chk(room_left(2) == 2, "R5 model room", room_left(2), 2);
    send_pkt(2, 3, -1);
    send_pkt(2, 2, -1);
    for (int i = 0; i < 9; i++) do_req(2, "R5 capacity");

    // R9: start-of-packet restarts an unfinished packet
    beat(3, 16'hB001, 1, 0, 0);
    beat(3, 16'hB002, 0, 0, 0);
    beat(3, 16'hB003, 1, 1, 0);
    idle();
    for (int i = 0; i < 2; i++) do_req(3, "R9 restart");

    // R10: strobe held high on channel 0 streams one word per cycle
    send_pkt(0, 5, -1);
    begin
      bit exp_v [7];
      logic [DW-1:0] exp_d [7];
      for (int j = 0; j < 7; j++) begin
        exp_v[j] = q_comm[0].size() > 0;
        exp_d[j] = exp_v[j] ? q_comm[0].pop_front() : '0;
      end
      @(negedge clk); req_write = 1; req_channel = '0;
      for (int i = 0; i < 9; i++) begin
        @(negedge clk);
        if (i == 6) req_write = 0;
        if (i >= 2) begin
          chk(out_valid == exp_v[i-2], "R10 stream valid", out_valid, exp_v[i-2]);
          if (exp_v[i-2]) chk(out_data == exp_d[i-2], "R10 stream data", out_data, exp_d[i-2]);
        end
      end
    end

    // Random mix
    for (int n = 0; n < 40; n++) begin
      int ch, len, ea;
      ch  = int'($urandom_range(NCH - 1));
      len = int'($urandom_range(1, 5));
      ea  = ($urandom_range(4) == 0) ? int'($urandom_range(len - 1)) : -1;
      send_pkt(ch, len, ea);
      if ($urandom_range(1) == 1)
        for (int k = 0; k < int'($urandom_range(1, 6)); k++)
          do_req(int'($urandom_range(NCH - 1)), (ea >= 0) ? "R3 random" : "R2 random");
    end
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < DEPTH + 1; k++) do_req(c, "R8 final drain");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule